// File: doc/BRIEF.md
# Bit-Serial SHA-256 Message Schedule Expander

This block builds the 64-word SHA-256 message schedule one bit per clock. Every 32-bit word moves along a single wire, least significant bit first, so the datapath is one bit wide. A host streams in the sixteen words of a message block. The block passes them straight through and also keeps them in a serial history line. On later words the host selects expansion, and the block then computes each new word from fixed taps on that history line. Three one-bit serial adders, each with its own carry flop, form the sum.

A word begins on the clock that carries bit 0, and the host marks that clock with `in_sow`. Words follow each other back to back, so a new word-start marker arrives every 32 clocks. The mode input `in_load` is sampled only on the word-start clock. A small controller holds the mode for the rest of the word. It has three states. `PH_IDLE` is the state after reset, before any word has started. `PH_LOAD` passes the input bit through. `PH_EXPAND` outputs the computed bit. Every word-start clock takes a transition. With `in_load` high it goes to `PH_LOAD`, and with `in_load` low it goes to `PH_EXPAND`, whatever the previous state. There is no transition back to `PH_IDLE` except through reset. The output bit and the output word-start marker appear one clock after the input clock they belong to.

Top module: `sched_bitserial_expander`

## Requirements
- R1: After reset the block is in `PH_IDLE`. Until the first `in_sow`, `w_bit` and `w_sow` stay 0 whatever `in_bit` does, and the history line does not shift.
- R2: Words are serial, LSB first. Bit b of a word is on the clock b cycles after its word-start clock. `w_sow` is high exactly one clock after each clock with `in_sow` high. `w_bit` carries bit b one clock after the input clock for bit b.
- R3: In a word started with `in_load`=1, the output word equals the input word, delayed by one clock.
- R4: In a word started with `in_load`=0, the output word is w[i] = s1(w[i-2]) + w[i-7] + s0(w[i-15]) + w[i-16] mod 2^32. Here w[i-k] is the k-th previous output word, whether it was loaded or expanded. s0(x) = ROTR7(x) ^ ROTR18(x) ^ SHR3(x), and s1(x) = ROTR17(x) ^ ROTR19(x) ^ SHR10(x).
- R5: `in_load` is sampled only on the word-start clock. Changes on bits 1 to 31 of a word have no effect on that word.
- R6: In an expanded word, `in_bit` has no effect on the output.
- R7: The carry of every serial adder is cleared at each word start, so no carry passes between words. This holds even when every operand is all ones.
- R8: The logical shifts fill with zeros. Bits 29 to 31 of SHR3 and bits 22 to 31 of SHR10 are 0, not wrapped copies of low bits.
- R9: Words run with no idle gaps. More than 16 loaded words are allowed, and expansion then uses the last 16 output words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_bit | input | 1 | Serial input word bit, LSB first |
| in_sow | input | 1 | High on the bit-0 clock of each word |
| in_load | input | 1 | Word mode, sampled on the word-start clock: 1 = load/pass, 0 = expand |
| w_bit | output | 1 | Serial schedule word bit, one clock after input |
| w_sow | output | 1 | High on the output clock carrying bit 0 |

## Verification
Every cycle, the assertions check the following. The output word-start marker follows the input marker by exactly one clock, and it stays low otherwise. The outputs stay quiet before the first word. Loaded bits pass through unchanged. The held mode does not change inside a word. Only the bench's scenarios can show that the expanded words are arithmetically correct, because each word depends on sixteen earlier ones across thousands of cycles. The same holds for carries from all-ones operands not leaking across word boundaries, for zero fill in the shifts, and for mode and data changes inside expanded words having no effect.

// File: rtl/sched_pkg.sv
package sched_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_LOAD   = 2'd1,
        PH_EXPAND = 2'd2
    } phase_e;

    // number of past words the recurrence reaches back over
    localparam int HIST_WORDS = 16;

    // small and large sigma constants
    localparam int S0_RA = 7;
    localparam int S0_RB = 18;
    localparam int S0_SH = 3;
    localparam int S1_RA = 17;
    localparam int S1_RB = 19;
    localparam int S1_SH = 10;

    // tap indices on the history line
    localparam int TAP_W16   = 0;
    localparam int TAP_W7    = 1;
    localparam int TAP_S0A_L = 2;
    localparam int TAP_S0A_H = 3;
    localparam int TAP_S0B_L = 4;
    localparam int TAP_S0B_H = 5;
    localparam int TAP_S0S   = 6;
    localparam int TAP_S1A_L = 7;
    localparam int TAP_S1A_H = 8;
    localparam int TAP_S1B_L = 9;
    localparam int TAP_S1B_H = 10;
    localparam int TAP_S1S   = 11;
    localparam int NTAP      = 12;

    // age in clocks of the bit a tap must deliver; the _H taps serve
    // rotate positions that wrap past the end of the word
    function automatic int tap_age(input int w, input int idx);
        case (idx)
            TAP_W16:   return 16 * w;
            TAP_W7:    return 7 * w;
            TAP_S0A_L: return 15 * w - S0_RA;
            TAP_S0A_H: return 16 * w - S0_RA;
            TAP_S0B_L: return 15 * w - S0_RB;
            TAP_S0B_H: return 16 * w - S0_RB;
            TAP_S0S:   return 15 * w - S0_SH;
            TAP_S1A_L: return 2 * w - S1_RA;
            TAP_S1A_H: return 3 * w - S1_RA;
            TAP_S1B_L: return 2 * w - S1_RB;
            TAP_S1B_H: return 3 * w - S1_RB;
            default:   return 2 * w - S1_SH;
        endcase
    endfunction

endpackage

// File: rtl/sched_history.sv
module sched_history #(
    parameter int WORD_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic                     push_bit,
    output logic [sched_pkg::NTAP-1:0] taps
);
    import sched_pkg::*;

    localparam int DEPTH = HIST_WORDS * WORD_W;

    // sr[0] holds the bit pushed one clock ago
    logic [DEPTH-1:0] sr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr <= '0;
        end else if (en) begin
            sr <= {sr[DEPTH-2:0], push_bit};
        end
    end

    for (genvar t = 0; t < NTAP; t++) begin : g_tap
        assign taps[t] = sr[tap_age(WORD_W, t) - 1];
    end

endmodule

// File: rtl/sched_sigma.sv
module sched_sigma #(
    parameter int WORD_W = 32,
    parameter int ROT_A  = 7,
    parameter int ROT_B  = 18,
    parameter int SHR    = 3,
    localparam int CNT_W = $clog2(WORD_W)
) (
    input  logic [CNT_W-1:0] bpos,
    input  logic             ra_lo,
    input  logic             ra_hi,
    input  logic             rb_lo,
    input  logic             rb_hi,
    input  logic             sh_bit,
    output logic             sig
);
    logic ra, rb, sh;

    always_comb begin
        ra  = ((int'(bpos) + ROT_A) < WORD_W) ? ra_lo : ra_hi;
        rb  = ((int'(bpos) + ROT_B) < WORD_W) ? rb_lo : rb_hi;
        sh  = ((int'(bpos) + SHR) < WORD_W) ? sh_bit : 1'b0;
        sig = ra ^ rb ^ sh;
    end

endmodule

// File: rtl/sched_serial_adder.sv
module sched_serial_adder (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic first,
    input  logic a,
    input  logic b,
    output logic s
);
    logic carry_q, cin, cout;

    always_comb begin
        cin  = first ? 1'b0 : carry_q;
        s    = a ^ b ^ cin;
        cout = (a & b) | (a & cin) | (b & cin);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carry_q <= 1'b0;
        end else if (en) begin
            carry_q <= cout;
        end
    end

endmodule

// File: rtl/sched_bitserial_expander.sv
module sched_bitserial_expander #(
    parameter int WORD_W = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_bit,
    input  logic in_sow,
    input  logic in_load,
    output logic w_bit,
    output logic w_sow
);
    import sched_pkg::*;

    localparam int CNT_W = $clog2(WORD_W);

    phase_e            state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, bpos;
    logic              active, new_bit, sum_bit;
    logic [NTAP-1:0]   taps;
    logic              s0_bit, s1_bit;
    logic [1:0]        op_a, op_b, part;

    // next state: every word start re-selects the mode
    always_comb begin
        state_d = state_q;
        if (in_sow) begin
            state_d = in_load ? PH_LOAD : PH_EXPAND;
        end
        bpos   = in_sow ? '0 : cnt_q;
        active = (state_d != PH_IDLE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= active ? bpos + 1'b1 : '0;
        end
    end

    // outputs of the current phase
    always_comb begin
        unique case (state_d)
            PH_IDLE:   new_bit = 1'b0;
            PH_LOAD:   new_bit = in_bit;
            PH_EXPAND: new_bit = sum_bit;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_bit <= 1'b0;
            w_sow <= 1'b0;
        end else begin
            w_bit <= new_bit;
            w_sow <= in_sow;
        end
    end

    sched_history #(.WORD_W(WORD_W)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (active),
        .push_bit (new_bit),
        .taps     (taps)
    );

    sched_sigma #(.WORD_W(WORD_W), .ROT_A(S0_RA), .ROT_B(S0_RB), .SHR(S0_SH)) u_s0 (
        .bpos   (bpos),
        .ra_lo  (taps[TAP_S0A_L]),
        .ra_hi  (taps[TAP_S0A_H]),
        .rb_lo  (taps[TAP_S0B_L]),
        .rb_hi  (taps[TAP_S0B_H]),
        .sh_bit (taps[TAP_S0S]),
        .sig    (s0_bit)
    );

    sched_sigma #(.WORD_W(WORD_W), .ROT_A(S1_RA), .ROT_B(S1_RB), .SHR(S1_SH)) u_s1 (
        .bpos   (bpos),
        .ra_lo  (taps[TAP_S1A_L]),
        .ra_hi  (taps[TAP_S1A_H]),
        .rb_lo  (taps[TAP_S1B_L]),
        .rb_hi  (taps[TAP_S1B_H]),
        .sh_bit (taps[TAP_S1S]),
        .sig    (s1_bit)
    );

    // adder tree: two leaf serial adders feed one root adder
    assign op_a = {s0_bit, s1_bit};
    assign op_b = {taps[TAP_W16], taps[TAP_W7]};

    for (genvar k = 0; k < 2; k++) begin : g_leaf
        sched_serial_adder u_add (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (active),
            .first (in_sow),
            .a     (op_a[k]),
            .b     (op_b[k]),
            .s     (part[k])
        );
    end

    sched_serial_adder u_root (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (active),
        .first (in_sow),
        .a     (part[0]),
        .b     (part[1]),
        .s     (sum_bit)
    );

endmodule

// File: rtl/sched_expander_chk.sv
module sched_expander_chk (
    input logic              clk,
    input logic              rst_n,
    input logic              in_bit,
    input logic              in_sow,
    input logic              w_bit,
    input logic              w_sow,
    input sched_pkg::phase_e state_q,
    input sched_pkg::phase_e state_d
);
    import sched_pkg::*;

    // R2: output word start follows the input marker by one clock
    p_sow_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_sow |=> w_sow);

    // R2: no output word start without an input marker
    p_sow_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_sow |=> !w_sow);

    // R1: quiet outputs before the first word
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_d == PH_IDLE) |=> (!w_bit && !w_sow));

    // R3: loaded bits pass through one clock later
    p_load_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_d == PH_LOAD) |=> (w_bit == $past(in_bit)));

    // R5: the mode is held across the body of a word
    p_mode_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_sow) |=> (state_q == $past(state_q)));

endmodule

bind sched_bitserial_expander sched_expander_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_bit  (in_bit),
    .in_sow  (in_sow),
    .w_bit   (w_bit),
    .w_sow   (w_sow),
    .state_q (state_q),
    .state_d (state_d)
);

// File: tb/tb_sched_bitserial_expander.sv
module tb_sched_bitserial_expander;

    logic clk = 1'b0;
    logic rst_n, in_bit, in_sow, in_load;
    logic w_bit, w_sow;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [31:0] blk  [64];
    logic [31:0] xs;

    always #10 clk = ~clk;  // 50 MHz

    sched_bitserial_expander dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_bit  (in_bit),
        .in_sow  (in_sow),
        .in_load (in_load),
        .w_bit   (w_bit),
        .w_sow   (w_sow)
    );

    function automatic logic [31:0] rotr(input logic [31:0] x, input int n);
        return (x >> n) | (x << (32 - n));
    endfunction

    function automatic logic [31:0] lsig0(input logic [31:0] x);
        return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
    endfunction

    function automatic logic [31:0] lsig1(input logic [31:0] x);
        return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
    endfunction

    function automatic logic [31:0] next_xs(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    // stream 64 words; blk[0..nload-1] loaded, rest computed in the bench.
    // noisy: toggle in_load and scramble in_bit on the body of expanded words
    task automatic run_block(input int nload, input bit noisy, input string req);
        logic [31:0] got, sow_got;
        for (int i = nload; i < 64; i++) begin
            blk[i] = lsig1(blk[i-2]) + blk[i-7] + lsig0(blk[i-15]) + blk[i-16];
        end
        for (int j = 0; j < 64; j++) begin
            got = '0;
            sow_got = '0;
            for (int b = 0; b < 32; b++) begin
                in_sow = (b == 0);
                if (j < nload) begin
                    in_load = (b == 0) ? 1'b1 : (noisy ? xs[b] : 1'b1);
                    in_bit  = blk[j][b];
                end else begin
                    in_load = (b == 0) ? 1'b0 : (noisy ? ~xs[b] : 1'b0);
                    in_bit  = noisy ? xs[31-b] : 1'b0;
                end
                if (noisy) xs = next_xs(xs);
                @(negedge clk);
                got[b]     = w_bit;
                sow_got[b] = w_sow;
            end
            if (j < nload)
                check(got == blk[j], {req, " R3 load word"}, got, blk[j]);
            else
                check(got == blk[j], {req, " R4 expanded word"}, got, blk[j]);
            check(sow_got == 32'h1, "R2 output word-start marker", sow_got, 32'h1);
        end
    endtask

    initial begin
        rst_n = 1'b0; in_bit = 1'b0; in_sow = 1'b0; in_load = 1'b0;
        xs = 32'h1234_5679;
        repeat (3) @(negedge clk);
        check(w_bit == 1'b0 && w_sow == 1'b0, "R1 reset outputs",
              {30'd0, w_sow, w_bit}, 32'd0);
        rst_n = 1'b1;
        // R1: toggling data before any word start must stay invisible
        for (int k = 0; k < 40; k++) begin
            in_bit = k[0];
            @(negedge clk);
            check(w_bit == 1'b0 && w_sow == 1'b0, "R1 idle quiet",
                  {30'd0, w_sow, w_bit}, 32'd0);
        end

        // "abc" padded block (R4)
        blk[0] = 32'h6162_6380;
        for (int i = 1; i < 15; i++) blk[i] = '0;
        blk[15] = 32'h0000_0018;
        run_block(16, 1'b0, "abc");
        check(blk[16] == 32'h6162_6380 && blk[63] == 32'h12B1_EDEB,
              "R4 reference sanity", blk[63], 32'h12B1_EDEB);

        // all ones: maximal carries, zero fill of shifts (R7, R8)
        for (int i = 0; i < 16; i++) blk[i] = 32'hFFFF_FFFF;
        run_block(16, 1'b0, "R7 R8 all-ones");

        // pseudo-random data with mid-word mode and data noise (R5, R6)
        for (int i = 0; i < 16; i++) begin
            xs = next_xs(xs);
            blk[i] = xs;
        end
        run_block(16, 1'b1, "R5 R6 noisy");

        // single high bits at the word top: shift fill corners (R8)
        for (int i = 0; i < 16; i++) blk[i] = (i % 2 == 0) ? 32'h8000_0000 : 32'hE000_0001;
        run_block(16, 1'b0, "R8 top-bit");

        // more than sixteen loaded words, back to back (R9)
        for (int i = 0; i < 20; i++) begin
            xs = next_xs(xs);
            blk[i] = xs;
        end
        run_block(20, 1'b0, "R9 long load");

        in_sow = 1'b0;
        @(negedge clk);
        check(w_sow == 1'b0, "R2 no marker after last word", {31'd0, w_sow}, 32'd0);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 200000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule